// File: doc/BRIEF.md
# Core Performance-State Transition Scheduler

This block decides which performance state a processor core runs at and when a change of that state takes effect. Every hardware thread on the core keeps one requested state index. Index 0 is the fastest state and larger indices are slower. The core's goal is the fastest state that any thread asks for. A thread that has gone idle or offline still counts with its last request. That goal is then limited by a separate count of usable states.

A change is never started at an arbitrary time. A free-running slot timer marks fixed update points, and a change can begin only at one of them. After a change begins, the block models the voltage and frequency settling time before it reports the new state as applied. Slowing down takes longer than speeding up.

A request can go back to the state that was in effect before an unfinished change. That case is handled as a quick revert, which completes after a short fixed delay. All times are parameters counted in reference-clock ticks, so the same logic can run on a real timebase or on a shortened one.

Top module: `pstate_xfer_sched`

## Requirements
- R1: While reset is asserted and after it is released, `applied_pstate` equals `RESET_PSTATE`, `busy` is 0 and `done` is 0. Every thread's stored request also starts at `RESET_PSTATE`.
- R2: A thread's stored request changes only on a cycle where its `req_we` bit is 1. Otherwise the thread keeps its last value, so an idle thread's old request keeps holding the core up.
- R3: The core goal is the smallest index among all stored thread requests, which is the fastest frequency.
- R4: The goal is clamped to `pstate_count - 1`. A count of 0 acts as 1, and a count above `NUM_PSTATES` acts as `NUM_PSTATES`.
- R5: A transition starts only at an update slot. `busy` rises only just after clock edge number k*`SLOT_TICKS` counted from reset release, so a request waits between 0 and `SLOT_TICKS` cycles.
- R6: A transition to a larger index (slower) keeps `busy` high for `DOWN_TICKS` cycles. A transition to a smaller index (faster) keeps it high for `UP_TICKS` cycles.
- R7: When a transition completes, `applied_pstate` and `applied_mult` take the new value on the same edge where `busy` falls, and `done` is high for exactly that one cycle. At no other time does `applied_pstate` change.
- R8: `applied_mult` equals `MULT_TOP - MULT_STEP * applied_pstate`, in units of 25 MHz.
- R9: During a transition, if the goal becomes equal to the state applied before that transition began, the transition ends `REVERT_TICKS` cycles after the first edge that sees the changed goal. The old state stays applied and `done` still pulses.
- R10: Any other goal change made during a transition does not alter that transition. The most recent goal is acted on at the first slot after it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; deasserted synchronously to clk |
| req_we | input | NUM_THREADS | Per-thread write strobe for a new requested state |
| req_pstate | input | NUM_THREADS x IW | Per-thread requested state index (0 is fastest) |
| pstate_count | input | CW | Number of usable states |
| applied_pstate | output | IW | State index currently applied to the core |
| applied_mult | output | MULT_W | Frequency multiplier of the applied state, 25 MHz units |
| busy | output | 1 | High from the slot that starts a transition until it settles |
| done | output | 1 | One-cycle pulse when a transition completes |

## Verification
The assertions assume that `rst_n` is released in step with the clock, that `SLOT_TICKS` is at least 2, and that the three settle delays are at least one tick. Under those assumptions, slot pulses are isolated and every settle window ends before the next decision. The bench changes requests and `pstate_count` only on falling edges. It issues the revert request in the first cycles of a settle window, well before the full delay could run out, so that the quick revert is never confused with a normal completion. It also reduces the time constants so that several slot periods fit in a short run.

// File: rtl/pst_pkg.sv
package pst_pkg;

  // Settle controller state
  typedef enum logic {
    XS_IDLE   = 1'b0,
    XS_SETTLE = 1'b1
  } xfer_state_e;

  // Larger of two tick counts, used to size the settle counter
  function automatic int max_ticks(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pst_req_arbiter.sv
module pst_req_arbiter #(
  parameter int NT           = 2,
  parameter int NP           = 8,
  parameter int IW           = 3,
  parameter int CW           = 4,
  parameter int RESET_PSTATE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NT-1:0]          req_we,
  input  logic [NT-1:0][IW-1:0]  req_pstate,
  input  logic [CW-1:0]          pstate_count,
  output logic [IW-1:0]          target
);

  logic [IW-1:0] thr_q [NT];
  logic [IW-1:0] thr_d [NT];
  logic [IW-1:0] fastest;
  logic [IW-1:0] lim;

  // Per-thread request holders: keep the last value unless written (R2)
  for (genvar t = 0; t < NT; t++) begin : g_thr
    always_comb begin
      thr_d[t] = thr_q[t];
      if (req_we[t]) begin
        thr_d[t] = req_pstate[t];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q[t] <= IW'(RESET_PSTATE);
      end else if (req_we[t]) begin
        thr_q[t] <= thr_d[t];
      end
    end

    // R3: no thread asks for something faster than the goal unless clamping applies
    p_target_fastest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (target <= thr_q[t]) || (target == lim));
  end

  // Fastest request over all threads (R3)
  always_comb begin
    fastest = '1;
    for (int t = 0; t < NT; t++) begin
      if (thr_q[t] < fastest) begin
        fastest = thr_q[t];
      end
    end
  end

  // Highest usable index from the count input (R4)
  always_comb begin
    if (pstate_count == '0) begin
      lim = '0;
    end else if (pstate_count > CW'(NP)) begin
      lim = IW'(NP - 1);
    end else begin
      lim = IW'(pstate_count - 1'b1);
    end
  end

  assign target = (fastest > lim) ? lim : fastest;

  // R4: goal never exceeds the usable range
  p_target_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pstate_count != '0) && (pstate_count <= CW'(NP))) |-> (CW'(target) < pstate_count));

endmodule

// File: rtl/pst_slot_timer.sv
module pst_slot_timer #(
  parameter int SLOT_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot
);

  localparam int SCW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [SCW-1:0] LAST = SCW'(SLOT_TICKS - 1);

  logic [SCW-1:0] cnt_q, cnt_d;

  assign slot = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (slot) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R5: update slots are isolated single-cycle events
  p_slot_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot |=> !slot);

endmodule

// File: rtl/pst_xfer_fsm.sv
module pst_xfer_fsm
  import pst_pkg::*;
#(
  parameter int IW           = 3,
  parameter int DOWN_TICKS   = 390,
  parameter int UP_TICKS     = 360,
  parameter int REVERT_TICKS = 1,
  parameter int RESET_PSTATE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot,
  input  logic [IW-1:0] target,
  output logic [IW-1:0] applied,
  output logic          busy,
  output logic          done
);

  localparam int MAXT = max_ticks(max_ticks(DOWN_TICKS, UP_TICKS), REVERT_TICKS);
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] DOWN_L = TW'(DOWN_TICKS - 1);
  localparam logic [TW-1:0] UP_L   = TW'(UP_TICKS - 1);
  localparam logic [TW-1:0] REV_L  = TW'(REVERT_TICKS - 1);

  xfer_state_e   st_q, st_d;
  logic [IW-1:0] applied_q, applied_d;
  logic [IW-1:0] prev_q, prev_d;   // state in effect before the running transition
  logic [IW-1:0] goal_q, goal_d;   // state the running transition heads for
  logic [TW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    st_d      = st_q;
    applied_d = applied_q;
    prev_d    = prev_q;
    goal_d    = goal_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    unique case (st_q)
      XS_IDLE: begin
        // R5, R10: act on the newest goal only at a slot
        if (slot && (target != applied_q)) begin
          st_d   = XS_SETTLE;
          prev_d = applied_q;
          goal_d = target;
          cnt_d  = (target < applied_q) ? UP_L : DOWN_L;   // R6
        end
      end
      XS_SETTLE: begin
        if (cnt_q == '0) begin
          st_d      = XS_IDLE;
          applied_d = goal_q;    // R7
          done_d    = 1'b1;
        end else if ((target == prev_q) && (goal_q != prev_q)) begin
          goal_d = prev_q;       // R9: quick revert
          cnt_d  = REV_L;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= XS_IDLE;
      applied_q <= IW'(RESET_PSTATE);
      prev_q    <= IW'(RESET_PSTATE);
      goal_q    <= IW'(RESET_PSTATE);
      cnt_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      applied_q <= applied_d;
      prev_q    <= prev_d;
      goal_q    <= goal_d;
      cnt_q     <= cnt_d;
      done_q    <= done_d;
    end
  end

  assign applied = applied_q;
  assign busy    = (st_q == XS_SETTLE);
  assign done    = done_q;

  // R7: the applied state moves only together with a done pulse
  p_applied_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(applied));

  // R7: done marks the end of a busy window and lasts one cycle
  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/pstate_xfer_sched.sv
module pstate_xfer_sched #(
  parameter int NUM_THREADS  = 2,
  parameter int NUM_PSTATES  = 8,
  parameter int MULT_W       = 8,
  parameter int MULT_TOP     = 100,
  parameter int MULT_STEP    = 4,
  parameter int SLOT_TICKS   = 1000,
  parameter int DOWN_TICKS   = 390,
  parameter int UP_TICKS     = 360,
  parameter int REVERT_TICKS = 1,
  parameter int RESET_PSTATE = 0,
  localparam int IW = (NUM_PSTATES > 1) ? $clog2(NUM_PSTATES) : 1,
  localparam int CW = $clog2(NUM_PSTATES + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_THREADS-1:0]          req_we,
  input  logic [NUM_THREADS-1:0][IW-1:0]  req_pstate,
  input  logic [CW-1:0]                   pstate_count,
  output logic [IW-1:0]                   applied_pstate,
  output logic [MULT_W-1:0]               applied_mult,
  output logic                            busy,
  output logic                            done
);

  logic [IW-1:0] target;
  logic          slot;

  pst_req_arbiter #(
    .NT           (NUM_THREADS),
    .NP           (NUM_PSTATES),
    .IW           (IW),
    .CW           (CW),
    .RESET_PSTATE (RESET_PSTATE)
  ) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_we       (req_we),
    .req_pstate   (req_pstate),
    .pstate_count (pstate_count),
    .target       (target)
  );

  pst_slot_timer #(
    .SLOT_TICKS (SLOT_TICKS)
  ) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (slot)
  );

  pst_xfer_fsm #(
    .IW           (IW),
    .DOWN_TICKS   (DOWN_TICKS),
    .UP_TICKS     (UP_TICKS),
    .REVERT_TICKS (REVERT_TICKS),
    .RESET_PSTATE (RESET_PSTATE)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot    (slot),
    .target  (target),
    .applied (applied_pstate),
    .busy    (busy),
    .done    (done)
  );

  // R8: multiplier of the applied state, 25 MHz per unit
  assign applied_mult = MULT_W'(MULT_TOP - MULT_STEP * int'(applied_pstate));

  // R5: a transition can only open right after a slot
  p_start_on_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(slot));

endmodule

// File: tb/pstate_xfer_sched_test.sv
module pstate_xfer_sched_test;

  localparam int SLOT = 40;
  localparam int DN   = 15;
  localparam int UPT  = 12;
  localparam int REV  = 2;
  localparam int RSTP = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      req_we;
  logic [1:0][2:0] req_pstate;
  logic [3:0]      pstate_count;
  logic [2:0]      applied_pstate;
  logic [7:0]      applied_mult;
  logic            busy;
  logic            done;

  int checks = 0;
  int errs   = 0;
  int ecnt   = 0;
  bit finished = 1'b0;

  pstate_xfer_sched #(
    .NUM_THREADS  (2),
    .NUM_PSTATES  (8),
    .MULT_W       (8),
    .MULT_TOP     (100),
    .MULT_STEP    (4),
    .SLOT_TICKS   (SLOT),
    .DOWN_TICKS   (DN),
    .UP_TICKS     (UPT),
    .REVERT_TICKS (REV),
    .RESET_PSTATE (RSTP)
  ) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_we         (req_we),
    .req_pstate     (req_pstate),
    .pstate_count   (pstate_count),
    .applied_pstate (applied_pstate),
    .applied_mult   (applied_mult),
    .busy           (busy),
    .done           (done)
  );

  always #2 clk = ~clk;

  // Edges since reset release
  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_req(input int thr, input int idx);
    @(negedge clk);
    req_we[thr]     = 1'b1;
    req_pstate[thr] = 3'(idx);
    @(negedge clk);
    req_we = '0;
  endtask

  // Wait for busy to rise and check slot alignment
  task automatic wait_rise(input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!busy && n < 3 * SLOT);
    chk({tag, " R5 busy rose"}, int'(busy), 1);
    chk({tag, " R5 slot aligned"}, ecnt % SLOT, 0);
  endtask

  // Count remaining busy samples, then check completion
  task automatic finish(input int remain, input int idx, input string tag);
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk({tag, " R6 settle length"}, n, remain);
    chk({tag, " R7 done at end"}, int'(done), 1);
    chk({tag, " R7 applied"}, int'(applied_pstate), idx);
    chk({tag, " R8 mult"}, int'(applied_mult), 100 - 4 * idx);
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, int'(done), 0);
  endtask

  task automatic expect_quiet(input int cycles, input int idx, input string tag);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk({tag, " no transition"}, seen, 0);
    chk({tag, " applied kept"}, int'(applied_pstate), idx);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_we = '0;
    req_pstate = '0;
    pstate_count = 4'd8;
    repeat (3) @(negedge clk);
    chk("R1 applied in reset", int'(applied_pstate), RSTP);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 applied after release", int'(applied_pstate), RSTP);
    chk("R1 done after release", int'(done), 0);
    chk("R8 reset mult", int'(applied_mult), 100 - 4 * RSTP);
  endtask

  task automatic t_idle_thread();
    expect_quiet(2 * SLOT, RSTP, "R1 R2 idle");
    write_req(0, 5);   // other thread still holds 2: goal stays 2
    expect_quiet(SLOT + 5, RSTP, "R2 R3 idle thread holds");
  endtask

  task automatic t_down_up();
    write_req(1, 5);
    wait_rise("down");
    finish(DN, 5, "down");
    write_req(1, 1);
    wait_rise("up");
    finish(UPT, 1, "up R3");
  endtask

  task automatic t_latch();
    write_req(1, 6);   // goal 5
    wait_rise("R10 first");
    write_req(0, 3);
    write_req(0, 7);   // goal now 6
    finish(DN - 4, 5, "R10 first kept");
    wait_rise("R10 latest");
    finish(DN, 6, "R10 latest");
  endtask

  task automatic t_revert();
    write_req(1, 0);   // goal 0, speed up
    wait_rise("R9 start");
    write_req(1, 6);   // back to the state before the transition
    finish(REV + 1, 6, "R9 revert");
    expect_quiet(SLOT + 5, 6, "R9 after revert");
  endtask

  task automatic t_clamp();
    @(negedge clk);
    pstate_count = 4'd4;   // indices 0..3; goal 6 clamped to 3
    wait_rise("R4 clamp");
    finish(UPT, 3, "R4 clamp");
    @(negedge clk);
    pstate_count = 4'd0;   // acts as 1: index 0 only
    wait_rise("R4 zero count");
    finish(UPT, 0, "R4 zero count");
    @(negedge clk);
    pstate_count = 4'd15;  // above range: acts as 8, goal 6
    wait_rise("R4 big count");
    finish(DN, 6, "R4 big count");
  endtask

  initial begin
    t_reset();
    t_idle_thread();
    t_down_up();
    t_latch();
    t_revert();
    t_clamp();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule